// File: doc/BRIEF.md
# Unipolar Stepper Motor Full-Step Sequencer

This block turns a fast system clock into a slow, evenly spaced stream of coil patterns for a two-phase unipolar stepper motor. An internal prescaler divides the 50 MHz system clock down to a 96 Hz step rate. On each step the four coil lines move to the next pattern of a full-step ring. In that ring exactly two neighbouring coils are energised at any time. With a 7.5 degree step angle, 48 steps make one revolution, so a running motor turns at 2 revolutions per second.

A direction select chooses whether the ring is walked forward (clockwise) or backward (counter-clockwise). An inhibit input freezes the ring so the motor holds its position. Both inputs matter only on the step cycle itself. The controller state is kept one-hot, with one flip-flop per ring position. A second set of four lines repeats the coil pattern for indicator LEDs. All eight outputs come straight from flip-flops, so they cannot glitch.

Top module: `stepper_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the coil and LED outputs to 4'b1100 and restarts the prescaler. A reset in the middle of a run also returns the outputs to 4'b1100.
- R2: With `cw` = 1 and `inhibit` = 0, each step moves the coil pattern forward through 1100, 0110, 0011, 1001 and then back to 1100.
- R3: With `cw` = 0 and `inhibit` = 0, each step moves the coil pattern backward through 1100, 1001, 0011, 0110 and then back to 1100.
- R4: While `inhibit` is 1 on a step cycle, the coil pattern stays unchanged.
- R5: Reversing `cw` takes effect at the next step. The step goes to the neighbour of the current pattern in the new direction, and no pattern is skipped.
- R6: The `led` outputs always equal the `coil` outputs.
- R7: A step happens once every `DIV` clock cycles, where `DIV` defaults to 520833 (50 MHz / 96 Hz). The first step comes on the `DIV`-th clock edge after reset is released. The coil pattern holds steady between steps.
- R8: `inhibit` and `cw` are sampled only on the step cycle. Values they take on other cycles have no effect.
- R9: The coil output always has exactly two adjacent coils on: one of 1100, 0110, 0011 or 1001. The internal state stays one-hot, and an illegal state returns to the 1100 position on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| inhibit | input | 1 | 1 = hold the current position on the step cycle |
| cw | input | 1 | 1 = clockwise (forward ring), 0 = counter-clockwise |
| coil | output | 4 | Registered coil drive pattern, bit 3 first coil |
| led | output | 4 | Registered copy of the coil pattern for LEDs |

## Verification
The assertions check on every cycle that:
- the LED lines match the coil lines;
- the pattern is always one of the four legal adjacent pairs and the state stays one-hot;
- nothing moves except on a step cycle;
- each step is a single rotation in the direction sampled on that cycle, or no change at all under inhibit.

Only the bench scenarios can show the things that need a sequence of cycles: the exact step spacing after reset, the full wrap of the ring in both directions, reversal with no skipped pattern, and that changes to `inhibit` or `cw` between steps are really ignored.

// File: rtl/stepper_seq.sv
module stepper_seq #(
  parameter int DIV = 520833
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inhibit,
  input  logic       cw,
  output logic [3:0] coil,
  output logic [3:0] led
);
  localparam int CNTW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(DIV - 1);
  localparam logic [3:0] HOME = 4'b0001;

  logic [CNTW-1:0] cnt;
  logic [3:0]      st, st_nx, pat_nx;
  logic            tick;

  assign tick = (cnt == LAST);

  always_comb begin
    if (!$onehot(st))
      st_nx = HOME;
    else if (tick && !inhibit)
      st_nx = cw ? {st[2:0], st[3]} : {st[0], st[3:1]};
    else
      st_nx = st;
  end

  assign pat_nx = {st_nx[0] | st_nx[3], st_nx[0] | st_nx[1],
                   st_nx[1] | st_nx[2], st_nx[2] | st_nx[3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      st   <= HOME;
      coil <= 4'b1100;
      led  <= 4'b1100;
    end else begin
      cnt  <= tick ? '0 : cnt + 1'b1;
      st   <= st_nx;
      coil <= pat_nx;
      led  <= pat_nx;
    end
  end
endmodule

// File: rtl/stepper_seq_chk.sv
module stepper_seq_chk #(
  parameter int DIV = 520833,
  localparam int CNTW = (DIV > 2) ? $clog2(DIV) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            inhibit,
  input logic            cw,
  input logic [3:0]      coil,
  input logic [3:0]      led,
  input logic [3:0]      st,
  input logic [CNTW-1:0] cnt
);
  logic step_cyc;
  assign step_cyc = (cnt == CNTW'(DIV - 1));

  assert_reset_home_R1: assert property (@(posedge clk)
    rst |=> (coil == 4'b1100 && cnt == '0));

  assert_fwd_step_R2: assert property (@(posedge clk) disable iff (rst)
    (step_cyc && !inhibit && cw) |=> coil == {$past(coil[0]), $past(coil[3:1])});

  assert_rev_step_R3: assert property (@(posedge clk) disable iff (rst)
    (step_cyc && !inhibit && !cw) |=> coil == {$past(coil[2:0]), $past(coil[3])});

  assert_inhibit_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (step_cyc && inhibit) |=> $stable(coil));

  assert_led_mirror_R6: assert property (@(posedge clk) disable iff (rst)
    led == coil);

  assert_quiet_between_R7: assert property (@(posedge clk) disable iff (rst)
    !step_cyc |=> $stable(coil));

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNTW'(DIV - 1));

  assert_adjacent_pair_R9: assert property (@(posedge clk) disable iff (rst)
    ($countones(coil) == 2 && coil != 4'b1010 && coil != 4'b0101));

  assert_onehot_state_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot(st));
endmodule

bind stepper_seq stepper_seq_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst(rst), .inhibit(inhibit), .cw(cw),
  .coil(coil), .led(led), .st(st), .cnt(cnt)
);

// File: tb/stepper_seq_tb.sv
`timescale 1ns/1ps
module stepper_seq_tb;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst, inhibit, cw;
  logic [3:0] coil, led;
  logic [3:0] exp_pat;
  int checks = 0, errors = 0;

  stepper_seq #(.DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .inhibit(inhibit), .cw(cw), .coil(coil), .led(led)
  );

  always #4 clk = ~clk;

  function automatic logic [3:0] fwd(input logic [3:0] p);
    case (p)
      4'b1100: return 4'b0110;
      4'b0110: return 4'b0011;
      4'b0011: return 4'b1001;
      default: return 4'b1100;
    endcase
  endfunction

  function automatic logic [3:0] rev(input logic [3:0] p);
    case (p)
      4'b1100: return 4'b1001;
      4'b1001: return 4'b0011;
      4'b0011: return 4'b0110;
      default: return 4'b1100;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, expv);
    end
  endtask

  task automatic check_out(input string req);
    check(req, coil, exp_pat);
    check("R6 led", led, exp_pat);
    checks++;
    if (!(coil == 4'b1100 || coil == 4'b0110 || coil == 4'b0011 || coil == 4'b1001)) begin
      errors++;
      $display("FAIL R9 actual=%b expected=adjacent pair", coil);
    end
  endtask

  task automatic one_step;
    repeat (DIV) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    exp_pat = 4'b1100;
    check_out("R1 reset");
  endtask

  task automatic t_period;
    repeat (DIV - 1) @(posedge clk);
    #1 check_out("R7 no step before DIV edges");
    @(posedge clk); #1;
    exp_pat = fwd(exp_pat);
    check_out("R7 step at DIV edge");
  endtask

  task automatic t_cw;
    cw = 1'b1;
    for (int i = 0; i < 4; i++) begin
      one_step();
      exp_pat = fwd(exp_pat);
      check_out("R2 forward");
    end
  endtask

  task automatic t_ccw;
    cw = 1'b0;
    for (int i = 0; i < 5; i++) begin
      one_step();
      exp_pat = rev(exp_pat);
      check_out("R3 reverse");
    end
  endtask

  task automatic t_inhibit;
    inhibit = 1'b1;
    for (int i = 0; i < 3; i++) begin
      one_step();
      check_out("R4 inhibit hold");
    end
    inhibit = 1'b0;
    one_step();
    exp_pat = rev(exp_pat);
    check_out("R4 resume after inhibit");
  endtask

  task automatic t_reverse;
    cw = 1'b1;
    one_step();
    exp_pat = fwd(exp_pat);
    check_out("R5 before reversal");
    cw = 1'b0;
    one_step();
    exp_pat = rev(exp_pat);
    check_out("R5 reversal no skip");
    cw = 1'b1;
    one_step();
    exp_pat = fwd(exp_pat);
    check_out("R5 reversal back");
  endtask

  task automatic t_sampling;
    inhibit = 1'b1;
    cw = 1'b0;
    repeat (DIV - 1) @(posedge clk);
    #1 inhibit = 1'b0;
    cw = 1'b1;
    @(posedge clk); #1;
    exp_pat = fwd(exp_pat);
    check_out("R8 inhibit/cw between steps ignored");
    inhibit = 1'b0;
    cw = 1'b1;
    repeat (DIV - 1) @(posedge clk);
    #1 inhibit = 1'b1;
    cw = 1'b0;
    @(posedge clk); #1;
    check_out("R8 inhibit on step cycle holds");
    inhibit = 1'b0;
  endtask

  task automatic t_mid_reset;
    cw = 1'b1;
    one_step();
    exp_pat = fwd(exp_pat);
    repeat (3) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    exp_pat = 4'b1100;
    check_out("R1 mid-run reset");
    t_period();
  endtask

  initial begin
    rst = 1'b1;
    inhibit = 1'b0;
    cw = 1'b1;
    exp_pat = 4'b1100;
    t_reset();
    t_period();
    t_cw();
    t_ccw();
    t_inhibit();
    t_reverse();
    t_sampling();
    t_mid_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule